// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps a physical file of `NUM_PHYS` 32-bit registers. A processor sees only 16 of them at a time, through a window whose base moves in steps of four registers. The controller holds the window base and a liveness bitmap that has one bit per base position. It also keeps the storage itself, so a logical register number turns into a physical row inside the block.

A processor pipeline drives one operation per cycle, together with its operands, the current program counter and the status-word bits that matter here. The operations are:

- a subroutine-entry step, which allocates the stack frame and rotates the window;
- a spill check before a register access;
- a windowed return;
- a stack-pointer move check;
- a restore of the base from the status word's saved-base field;
- a direct write of the base.

Every operation completes in the cycle that samples it. Exceptions, the computed return address, and the new base and bitmap are all visible in the following cycle. The bitmap scans choose between 4-, 8- and 12-register spill and refill exceptions. The exception handlers and the memory traffic of a spill lie outside the block.

Top module: `wrf_ctrl`

## Requirements
- R1: Reset sets the base to 0, sets the liveness bitmap to only bit 0, clears `exc_valid` and `ret_valid`, and clears every register to 0. Without `op_valid`, the base and bitmap hold.
- R2: Logical register r reads physical row (base*4 + r) mod `NUM_PHYS`, which wraps past the top of the file. `rf_pidx` gives that row. An external write with `rf_we` uses the same mapping and is seen on the next cycle.
- R3: Entry (`op_code` 1) is illegal when `op_sel` > 3, when `st_woe` is 0, or when `st_excm` is 1. The next cycle then shows `exc_valid` with `exc_kind` 1 and `exc_pc` equal to the sampled `cur_pc`. The base, the bitmap and the registers are left unchanged.
- R4: A legal entry writes logical register (`st_callinc`*4 + s) with register s minus `op_imm`*8, where s = `op_sel`. It then adds `st_callinc` to the base modulo `NUM_PHYS`/4 and sets the bitmap bit at the new base.
- R5: A spill check (`op_code` 2), with w = `op_sel[1:0]`, scans offsets 1 to w from the base. At the first offset n whose bitmap bit is set, it moves the base to m = base+n and raises an exception. `exc_oldbase` gives the old base and `exc_pc` gives `cur_pc`.
- R6: The spill kind is 2 (four registers) if the bit at m+1 is set. Otherwise it is 3 (eight) if the bit at m+2 is set. Otherwise it is 4 (twelve).
- R7: A spill check with no hit, with w = 0, with `st_woe` at 0 or with `st_excm` at 1 changes nothing and raises nothing.
- R8: A return (`op_code` 3) takes n from bits 31:30 of logical register 0. It scans base-1, base-2 and base-3 in that order, and m is the first offset whose bit is set, or 0 if none is. The return is illegal (`exc_kind` 1) if n is 0, if m is nonzero and not equal to n, or if the mode bits are wrong.
- R9: A legal return loads `ret_pc` with `cur_pc[31:30]` joined to register 0 bits 29:0 and subtracts n from the base. If the bit at the new base is set, it clears the old base's bit and raises `ret_valid`.
- R10: If that bit is clear, the return instead raises a refill of kind 4+n (5, 6 or 7). The base stays rotated, the bitmap is unchanged, and `exc_oldbase` gives the base before the return.
- R11: A stack-pointer move (`op_code` 4) raises kind 8 when none of the bits at base-1, base-2 and base-3 is set, and does nothing otherwise.
- R12: A restore (`op_code` 5) loads the base from `st_oldbase`. A base write (`op_code` 6) loads it from `op_wdata` modulo `NUM_PHYS`/4. Neither one changes the bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | 1 entry, 2 spill check, 3 return, 4 stack move, 5 restore, 6 base write |
| op_sel | input | 4 | Entry source register, or spill-check reach in bits 1:0 |
| op_imm | input | 12 | Entry frame size in units of 8 bytes |
| op_wdata | input | 32 | Value for a base write |
| cur_pc | input | 32 | Program counter of the operation |
| st_woe | input | 1 | Status word: window-overflow enable |
| st_excm | input | 1 | Status word: exception mode |
| st_callinc | input | 2 | Status word: call increment |
| st_oldbase | input | BW | Status word: saved base |
| rf_we | input | 1 | External register write |
| rf_waddr | input | 4 | Logical register to write |
| rf_wdata | input | 32 | Write data |
| rf_raddr | input | 4 | Logical register to read |
| rf_rdata | output | 32 | Read data |
| rf_pidx | output | PW | Physical row of `rf_raddr` |
| win_base | output | BW | Current window base |
| win_start | output | NWIN | Liveness bitmap |
| ret_valid | output | 1 | A return completed in the last cycle |
| ret_pc | output | 32 | Computed return address |
| exc_valid | output | 1 | Exception raised in the last cycle |
| exc_kind | output | 4 | 1 illegal, 2/3/4 spill 4/8/12, 5/6/7 refill 4/8/12, 8 stack move |
| exc_pc | output | 32 | PC of the excepting operation |
| exc_oldbase | output | BW | Base before the excepting operation |

## Verification
The hardest situation to reach is a spill or refill of eight or twelve registers. It needs a bitmap with a particular gap pattern behind or ahead of the base. Legal calls set bits only at the base they arrive at, and returns clear them again. The stimulus builds these patterns by hand. It sets bits with entries issued from chosen bases, then moves the base with direct writes so that the scan lands on the gap. A long random phase follows, with register 0 rewritten so that return counts of every value appear. A behavioural model checks each cycle of both phases.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    typedef enum logic [2:0] {
        OP_NONE         = 3'd0,
        OP_CALL_ENTRY   = 3'd1,
        OP_SPILL_CHECK  = 3'd2,
        OP_WIN_RETURN   = 3'd3,
        OP_SP_MOVE      = 3'd4,
        OP_BASE_RESTORE = 3'd5,
        OP_BASE_WRITE   = 3'd6
    } wrf_op_e;

    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_ILLEGAL = 4'd1,
        EXC_SPILL4  = 4'd2,
        EXC_SPILL8  = 4'd3,
        EXC_SPILL12 = 4'd4,
        EXC_FILL4   = 4'd5,
        EXC_FILL8   = 4'd6,
        EXC_FILL12  = 4'd7,
        EXC_ALLOCA  = 4'd8
    } wrf_exc_e;

endpackage

// File: rtl/wrf_scan.sv
module wrf_scan #(
    parameter int NWIN = 16,
    parameter int BW   = 4
) (
    input  logic [BW-1:0]   base,
    input  logic [NWIN-1:0] start,
    output logic [5:0]      ahead,
    output logic [3:1]      behind
);
    // ahead[k] is the bitmap bit at base+k, behind[k] the bit at base-k
    for (genvar k = 0; k < 6; k++) begin : g_ahead
        logic [BW-1:0] idx;
        assign idx      = base + BW'(k);
        assign ahead[k] = start[idx];
    end

    for (genvar k = 1; k < 4; k++) begin : g_behind
        logic [BW-1:0] idx;
        assign idx       = base - BW'(k);
        assign behind[k] = start[idx];
    end
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile #(
    parameter int NUM_PHYS = 64,
    parameter int DW       = 32,
    parameter int BW       = 4,
    localparam int PW      = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] base,
    input  logic          we,
    input  logic [3:0]    waddr,
    input  logic [DW-1:0] wdata,
    input  logic [3:0]    ra_a,
    output logic [DW-1:0] rd_a,
    output logic [PW-1:0] pidx_a,
    input  logic [3:0]    ra_b,
    output logic [DW-1:0] rd_b
);
    logic [DW-1:0] mem [NUM_PHYS];
    logic [PW-1:0] pidx_w;
    logic [PW-1:0] pidx_b;

    // base*4 is exactly PW bits wide, so the truncated sum wraps the file
    assign pidx_a = PW'({base, 2'b00}) + PW'(ra_a);
    assign pidx_b = PW'({base, 2'b00}) + PW'(ra_b);
    assign pidx_w = PW'({base, 2'b00}) + PW'(waddr);

    assign rd_a = mem[pidx_a];
    assign rd_b = mem[pidx_b];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[pidx_w] <= wdata;
        end
    end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
    import wrf_pkg::*;
#(
    parameter int NUM_PHYS = 64,
    localparam int NWIN    = NUM_PHYS / 4,
    localparam int BW      = $clog2(NWIN),
    localparam int PW      = $clog2(NUM_PHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [3:0]      op_sel,
    input  logic [11:0]     op_imm,
    input  logic [31:0]     op_wdata,
    input  logic [31:0]     cur_pc,
    input  logic            st_woe,
    input  logic            st_excm,
    input  logic [1:0]      st_callinc,
    input  logic [BW-1:0]   st_oldbase,
    input  logic            rf_we,
    input  logic [3:0]      rf_waddr,
    input  logic [31:0]     rf_wdata,
    input  logic [3:0]      rf_raddr,
    output logic [31:0]     rf_rdata,
    output logic [PW-1:0]   rf_pidx,
    output logic [BW-1:0]   win_base,
    output logic [NWIN-1:0] win_start,
    output logic            ret_valid,
    output logic [31:0]     ret_pc,
    output logic            exc_valid,
    output logic [3:0]      exc_kind,
    output logic [31:0]     exc_pc,
    output logic [BW-1:0]   exc_oldbase
);
    logic [BW-1:0]   base_q, base_d;
    logic [NWIN-1:0] start_q, start_d;
    logic            ret_v_q, ret_v_d;
    logic [31:0]     ret_pc_q, ret_pc_d;
    logic            exc_v_q, exc_v_d;
    wrf_exc_e        exc_k_q, exc_k_d;
    logic [31:0]     exc_pc_q, exc_pc_d;
    logic [BW-1:0]   exc_ob_q, exc_ob_d;

    wrf_op_e         op;
    logic            mode_ok;
    logic [5:0]      ahead;
    logic [3:1]      behind;
    logic [3:0]      rb_addr;
    logic [31:0]     rb_data;
    logic [1:0]      ret_n;
    logic [1:0]      ret_m;
    logic [BW-1:0]   ret_base;
    logic [BW-1:0]   ent_base;
    logic [1:0]      chk_n;
    logic            ent_we;
    logic            file_we;
    logic [3:0]      file_waddr;
    logic [31:0]     file_wdata;

    assign op      = op_valid ? wrf_op_e'(op_code) : OP_NONE;
    assign mode_ok = st_woe & ~st_excm;

    wrf_scan #(.NWIN(NWIN), .BW(BW)) u_scan (
        .base   (base_q),
        .start  (start_q),
        .ahead  (ahead),
        .behind (behind)
    );

    // second read port: register 0 for a return, the source register otherwise
    assign rb_addr = (op == OP_WIN_RETURN) ? 4'd0 : {2'b00, op_sel[1:0]};

    assign file_we    = ent_we | rf_we;
    assign file_waddr = ent_we ? {st_callinc, op_sel[1:0]} : rf_waddr;
    assign file_wdata = ent_we ? (rb_data - {17'd0, op_imm, 3'b000}) : rf_wdata;

    wrf_regfile #(.NUM_PHYS(NUM_PHYS), .DW(32), .BW(BW)) u_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (base_q),
        .we     (file_we),
        .waddr  (file_waddr),
        .wdata  (file_wdata),
        .ra_a   (rf_raddr),
        .rd_a   (rf_rdata),
        .pidx_a (rf_pidx),
        .ra_b   (rb_addr),
        .rd_b   (rb_data)
    );

    assign ret_n    = rb_data[31:30];
    assign ret_base = base_q - BW'(ret_n);
    assign ent_base = base_q + BW'(st_callinc);

    // nearest live frame below the base, in scan order base-1, -2, -3
    always_comb begin
        if (behind[1])      ret_m = 2'd1;
        else if (behind[2]) ret_m = 2'd2;
        else if (behind[3]) ret_m = 2'd3;
        else                ret_m = 2'd0;
    end

    // first live frame within the reach of a spill check
    always_comb begin
        if (op_sel[1:0] >= 2'd1 && ahead[1])      chk_n = 2'd1;
        else if (op_sel[1:0] >= 2'd2 && ahead[2]) chk_n = 2'd2;
        else if (op_sel[1:0] == 2'd3 && ahead[3]) chk_n = 2'd3;
        else                                      chk_n = 2'd0;
    end

    always_comb begin
        base_d   = base_q;
        start_d  = start_q;
        ret_v_d  = 1'b0;
        ret_pc_d = ret_pc_q;
        exc_v_d  = 1'b0;
        exc_k_d  = EXC_NONE;
        exc_pc_d = exc_pc_q;
        exc_ob_d = exc_ob_q;
        ent_we   = 1'b0;
        unique case (op)
            OP_CALL_ENTRY: begin
                if (op_sel > 4'd3 || !mode_ok) begin
                    exc_v_d = 1'b1;
                    exc_k_d = EXC_ILLEGAL;
                end else begin
                    ent_we            = 1'b1;
                    base_d            = ent_base;
                    start_d[ent_base] = 1'b1;
                end
            end
            OP_SPILL_CHECK: begin
                if (mode_ok && chk_n != 2'd0) begin
                    exc_v_d = 1'b1;
                    base_d  = base_q + BW'(chk_n);
                    unique case (chk_n)
                        2'd1:    exc_k_d = ahead[2] ? EXC_SPILL4 : (ahead[3] ? EXC_SPILL8 : EXC_SPILL12);
                        2'd2:    exc_k_d = ahead[3] ? EXC_SPILL4 : (ahead[4] ? EXC_SPILL8 : EXC_SPILL12);
                        default: exc_k_d = ahead[4] ? EXC_SPILL4 : (ahead[5] ? EXC_SPILL8 : EXC_SPILL12);
                    endcase
                end
            end
            OP_WIN_RETURN: begin
                if (ret_n == 2'd0 || (ret_m != 2'd0 && ret_m != ret_n) || !mode_ok) begin
                    exc_v_d = 1'b1;
                    exc_k_d = EXC_ILLEGAL;
                end else begin
                    ret_pc_d = {cur_pc[31:30], rb_data[29:0]};
                    base_d   = ret_base;
                    if (start_q[ret_base]) begin
                        start_d[base_q] = 1'b0;
                        ret_v_d         = 1'b1;
                    end else begin
                        exc_v_d = 1'b1;
                        exc_k_d = wrf_exc_e'(4'd4 + {2'b00, ret_n});
                    end
                end
            end
            OP_SP_MOVE: begin
                if (behind == 3'b000) begin
                    exc_v_d = 1'b1;
                    exc_k_d = EXC_ALLOCA;
                end
            end
            OP_BASE_RESTORE: base_d = st_oldbase;
            OP_BASE_WRITE:   base_d = op_wdata[BW-1:0];
            default: ;
        endcase
        if (exc_v_d) begin
            exc_pc_d = cur_pc;
            exc_ob_d = base_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            start_q  <= NWIN'(1);
            ret_v_q  <= 1'b0;
            ret_pc_q <= '0;
            exc_v_q  <= 1'b0;
            exc_k_q  <= EXC_NONE;
            exc_pc_q <= '0;
            exc_ob_q <= '0;
        end else begin
            base_q   <= base_d;
            start_q  <= start_d;
            ret_v_q  <= ret_v_d;
            ret_pc_q <= ret_pc_d;
            exc_v_q  <= exc_v_d;
            exc_k_q  <= exc_k_d;
            exc_pc_q <= exc_pc_d;
            exc_ob_q <= exc_ob_d;
        end
    end

    assign win_base    = base_q;
    assign win_start   = start_q;
    assign ret_valid   = ret_v_q;
    assign ret_pc      = ret_pc_q;
    assign exc_valid   = exc_v_q;
    assign exc_kind    = exc_k_q;
    assign exc_pc      = exc_pc_q;
    assign exc_oldbase = exc_ob_q;
endmodule

// File: rtl/wrf_ctrl_chk.sv
module wrf_ctrl_chk #(
    parameter int NWIN = 16,
    parameter int BW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [2:0]      op_code,
    input logic [3:0]      op_sel,
    input logic            st_woe,
    input logic            st_excm,
    input logic [BW-1:0]   win_base,
    input logic [NWIN-1:0] win_start,
    input logic            ret_valid,
    input logic            exc_valid,
    input logic [3:0]      exc_kind
);
    AST_IDLE_HOLDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(win_base) && $stable(win_start)); // R1

    AST_BAD_SOURCE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1 && op_sel > 4'd3) |=> (exc_valid && exc_kind == 4'd1)); // R3

    AST_ENTRY_MARKS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1 && op_sel <= 4'd3 && st_woe && !st_excm)
        |=> (win_start[win_base] && !exc_valid)); // R4

    AST_SPILL_LANDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_kind >= 4'd2 && exc_kind <= 4'd4) |-> win_start[win_base]); // R5

    AST_RETURN_LANDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (win_start[win_base] && !exc_valid)); // R9

    AST_FILL_LANDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_kind >= 4'd5 && exc_kind <= 4'd7) |-> !win_start[win_base]); // R10

    AST_KIND_WHEN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_kind != 4'd0 && exc_kind <= 4'd8)); // R6
endmodule

bind wrf_ctrl wrf_ctrl_chk #(.NWIN(NWIN), .BW(BW)) u_wrf_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_sel    (op_sel),
    .st_woe    (st_woe),
    .st_excm   (st_excm),
    .win_base  (win_base),
    .win_start (win_start),
    .ret_valid (ret_valid),
    .exc_valid (exc_valid),
    .exc_kind  (exc_kind)
);

// File: tb/test_wrf_ctrl.sv
module test_wrf_ctrl;
    localparam int NP = 64;
    localparam int NW = NP / 4;
    localparam int BW = $clog2(NW);
    localparam int PW = $clog2(NP);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [2:0]      op_code = '0;
    logic [3:0]      op_sel = '0;
    logic [11:0]     op_imm = '0;
    logic [31:0]     op_wdata = '0;
    logic [31:0]     cur_pc = '0;
    logic            st_woe = 1'b1;
    logic            st_excm = 1'b0;
    logic [1:0]      st_callinc = '0;
    logic [BW-1:0]   st_oldbase = '0;
    logic            rf_we = 1'b0;
    logic [3:0]      rf_waddr = '0;
    logic [31:0]     rf_wdata = '0;
    logic [3:0]      rf_raddr = '0;
    logic [31:0]     rf_rdata;
    logic [PW-1:0]   rf_pidx;
    logic [BW-1:0]   win_base;
    logic [NW-1:0]   win_start;
    logic            ret_valid;
    logic [31:0]     ret_pc;
    logic            exc_valid;
    logic [3:0]      exc_kind;
    logic [31:0]     exc_pc;
    logic [BW-1:0]   exc_oldbase;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk; // 50 MHz

    wrf_ctrl #(.NUM_PHYS(NP)) i_wrf_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_sel(op_sel), .op_imm(op_imm), .op_wdata(op_wdata), .cur_pc(cur_pc),
        .st_woe(st_woe), .st_excm(st_excm), .st_callinc(st_callinc),
        .st_oldbase(st_oldbase), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_pidx(rf_pidx), .win_base(win_base), .win_start(win_start),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .exc_valid(exc_valid),
        .exc_kind(exc_kind), .exc_pc(exc_pc), .exc_oldbase(exc_oldbase)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0]   mrf [NP];
    int            mbase;
    logic [NW-1:0] mstart;
    logic          m_ret_v, m_exc_v;
    logic [31:0]   m_ret_pc, m_exc_pc;
    int            m_exc_k, m_exc_ob;
    string         m_tag = "R1";

    function automatic int wrapw(input int v);
        return ((v % NW) + NW) % NW;
    endfunction

    function automatic int row(input int b, input int r);
        return (b * 4 + r) % NP;
    endfunction

    function automatic bit live(input int k);
        return mstart[wrapw(k)];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) mrf[i] = '0;
            mbase = 0; mstart = 1; m_ret_v = 0; m_exc_v = 0;
            m_ret_pc = '0; m_exc_pc = '0; m_exc_k = 0; m_exc_ob = 0;
            m_tag = "R1";
        end else begin
            int ob, n, m, hit;
            bit ok;
            logic [31:0] r0;
            ob = mbase;
            ok = st_woe && !st_excm;
            m_ret_v = 0; m_exc_v = 0; m_exc_k = 0;
            m_tag = "R2";
            if (op_valid) begin
                case (op_code)
                    3'd1: begin
                        if (op_sel > 3 || !ok) begin
                            m_exc_v = 1; m_exc_k = 1; m_tag = "R3";
                        end else begin
                            mrf[row(mbase, st_callinc * 4 + op_sel)] =
                                mrf[row(mbase, op_sel)] - op_imm * 8;
                            mbase = wrapw(mbase + st_callinc);
                            mstart[mbase] = 1'b1;
                            m_tag = "R4";
                        end
                    end
                    3'd2: begin
                        hit = 0;
                        m_tag = "R7";
                        if (ok) begin
                            for (int k = 1; k <= op_sel % 4; k++) begin
                                if (hit == 0 && live(mbase + k)) hit = k;
                            end
                        end
                        if (hit != 0) begin
                            m = mbase + hit;
                            m_exc_v = 1;
                            m_exc_k = live(m + 1) ? 2 : (live(m + 2) ? 3 : 4);
                            mbase = wrapw(m);
                            m_tag = "R5/R6";
                        end
                    end
                    3'd3: begin
                        r0 = mrf[row(mbase, 0)];
                        n = int'(r0[31:30]);
                        m = 0;
                        for (int k = 3; k >= 1; k--) if (live(mbase - k)) m = k;
                        if (n == 0 || (m != 0 && m != n) || !ok) begin
                            m_exc_v = 1; m_exc_k = 1; m_tag = "R8";
                        end else begin
                            m_ret_pc = {cur_pc[31:30], r0[29:0]};
                            mbase = wrapw(mbase - n);
                            if (mstart[mbase]) begin
                                mstart[ob] = 1'b0; m_ret_v = 1; m_tag = "R9";
                            end else begin
                                m_exc_v = 1; m_exc_k = 4 + n; m_tag = "R10";
                            end
                        end
                    end
                    3'd4: begin
                        m_tag = "R11";
                        if (!live(mbase - 1) && !live(mbase - 2) && !live(mbase - 3)) begin
                            m_exc_v = 1; m_exc_k = 8;
                        end
                    end
                    3'd5: begin mbase = wrapw(int'(st_oldbase)); m_tag = "R12"; end
                    3'd6: begin mbase = wrapw(int'(op_wdata[15:0])); m_tag = "R12"; end
                    default: ;
                endcase
            end else if (rf_we) begin
                mrf[row(mbase, rf_waddr)] = rf_wdata;
            end
            if (m_exc_v) begin
                m_exc_pc = cur_pc;
                m_exc_ob = ob;
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(input bit good, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] erd;
        erd = mrf[row(mbase, rf_raddr)];
        chk(win_base == BW'(mbase), m_tag, "win_base", 32'(win_base), 32'(mbase));
        chk(win_start == mstart, m_tag, "win_start", 32'(win_start), 32'(mstart));
        chk(exc_valid == m_exc_v, m_tag, "exc_valid", 32'(exc_valid), 32'(m_exc_v));
        chk(exc_kind == 4'(m_exc_k), m_tag, "exc_kind", 32'(exc_kind), 32'(m_exc_k));
        chk(exc_pc == m_exc_pc, m_tag, "exc_pc", exc_pc, m_exc_pc);
        chk(exc_oldbase == BW'(m_exc_ob), m_tag, "exc_oldbase", 32'(exc_oldbase), 32'(m_exc_ob));
        chk(ret_valid == m_ret_v, m_tag, "ret_valid", 32'(ret_valid), 32'(m_ret_v));
        chk(ret_pc == m_ret_pc, m_tag, "ret_pc", ret_pc, m_ret_pc);
        chk(rf_rdata == erd, "R2", "rf_rdata", rf_rdata, erd);
        chk(rf_pidx == PW'(row(mbase, rf_raddr)), "R2", "rf_pidx", 32'(rf_pidx),
            32'(row(mbase, rf_raddr)));
    endtask

    initial begin
        @(posedge clk);
        forever begin
            @(posedge clk);
            #5;
            compare();
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input logic [2:0] code, input logic [3:0] sel,
                         input logic [11:0] imm, input logic [31:0] wd,
                         input logic woe, input logic excm, input logic [1:0] ci);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_sel = sel; op_imm = imm;
        op_wdata = wd; st_woe = woe; st_excm = excm; st_callinc = ci;
        cur_pc = $urandom; rf_we = 1'b0; rf_raddr = 4'($urandom);
    endtask

    task automatic wr(input logic [3:0] r, input logic [31:0] d);
        @(negedge clk);
        op_valid = 1'b0; rf_we = 1'b1; rf_waddr = r; rf_wdata = d;
        rf_raddr = r;
    endtask

    task automatic idle(input logic [3:0] r);
        @(negedge clk);
        op_valid = 1'b0; rf_we = 1'b0; rf_raddr = r;
    endtask

    initial begin
        #(20 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4'd0);                                  // R1 reset state observed
        for (int r = 0; r < 16; r++) wr(4'(r), 32'h0100_0000 + 32'(r * 16));
        idle(4'd1);
        // R3 illegal entries
        drive(3'd1, 4'd5, 12'd2, 0, 1, 0, 2'd1);
        drive(3'd1, 4'd1, 12'd2, 0, 0, 0, 2'd1);
        drive(3'd1, 4'd1, 12'd2, 0, 1, 1, 2'd1);
        // R4 legal entries: base 0 -> 1 -> 3 -> 6
        drive(3'd1, 4'd1, 12'd4, 0, 1, 0, 2'd1);
        drive(3'd1, 4'd1, 12'd8, 0, 1, 0, 2'd2);
        drive(3'd1, 4'd2, 12'd1, 0, 1, 0, 2'd3);
        idle(4'd13);
        // R7 no hit; R12 base write; R5/R6 spill wrapping through 0
        drive(3'd2, 4'd3, 0, 0, 1, 0, 2'd0);
        drive(3'd6, 0, 0, 32'd14, 1, 0, 2'd0);
        drive(3'd2, 4'd3, 0, 0, 1, 0, 2'd0);
        drive(3'd6, 0, 0, 32'd20, 1, 0, 2'd0);       // R12 modulo
        st_oldbase = 4'd6;
        drive(3'd5, 0, 0, 0, 1, 0, 2'd0);            // R12 restore
        // R9 legal return n=3 landing on base 3
        wr(4'd0, {2'b11, 30'h0000_1230});
        drive(3'd3, 0, 0, 0, 1, 0, 2'd0);
        // R8 illegal returns
        wr(4'd0, 32'h0000_0040);
        drive(3'd3, 0, 0, 0, 1, 0, 2'd0);
        wr(4'd0, {2'b01, 30'h44});
        drive(3'd3, 0, 0, 0, 1, 0, 2'd0);
        wr(4'd0, {2'b10, 30'h48});
        drive(3'd3, 0, 0, 0, 0, 0, 2'd0);
        drive(3'd3, 0, 0, 0, 1, 0, 2'd0);            // R9 legal n=2
        // R10 refills of every size
        drive(3'd6, 0, 0, 32'd10, 1, 0, 2'd0);
        wr(4'd0, {2'b01, 30'h50});
        drive(3'd3, 0, 0, 0, 1, 0, 2'd0);
        wr(4'd0, {2'b10, 30'h54});
        drive(3'd3, 0, 0, 0, 1, 0, 2'd0);
        wr(4'd0, {2'b11, 30'h58});
        drive(3'd3, 0, 0, 0, 1, 0, 2'd0);
        // R11 stack move with and without a live frame behind
        drive(3'd4, 0, 0, 0, 1, 0, 2'd0);
        drive(3'd6, 0, 0, 32'd12, 1, 0, 2'd0);
        drive(3'd4, 0, 0, 0, 1, 0, 2'd0);
        // R6 twelve- and eight-register spills
        drive(3'd6, 0, 0, 32'd5, 1, 0, 2'd0);
        drive(3'd1, 4'd0, 12'd1, 0, 1, 0, 2'd3);     // bit 8
        drive(3'd6, 0, 0, 32'd6, 1, 0, 2'd0);
        drive(3'd2, 4'd3, 0, 0, 1, 1, 2'd0);         // R7 mode blocks it
        drive(3'd2, 4'd3, 0, 0, 1, 0, 2'd0);         // spill 12
        drive(3'd6, 0, 0, 32'd7, 1, 0, 2'd0);
        drive(3'd1, 4'd0, 12'd1, 0, 1, 0, 2'd3);     // bit 10
        drive(3'd6, 0, 0, 32'd6, 1, 0, 2'd0);
        drive(3'd2, 4'd3, 0, 0, 1, 0, 2'd0);         // spill 8
        drive(3'd6, 0, 0, 32'd15, 1, 0, 2'd0);
        idle(4'd15);                                 // R2 wrap past the top
        idle(4'd3);
        // random phase
        for (int i = 0; i < 2000; i++) begin
            if ($urandom % 4 == 0) begin
                wr(4'($urandom), $urandom);
            end else begin
                drive(3'(1 + $urandom % 6),
                      ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4),
                      12'($urandom), 32'($urandom % 64),
                      ($urandom % 8 != 0), ($urandom % 8 == 0), 2'($urandom));
                st_oldbase = BW'($urandom);
            end
        end
        idle(4'd0);
        idle(4'd0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule